// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Register

This block gathers single-cycle event pulses from the parts of a 10/100 Ethernet controller and holds each one in its own sticky status bit. The event sources are the receive and transmit completion logic, the two FIFOs, a bus integrity checker, the receive buffer manager and a fragment-length comparator. The host reads the status through a small synchronous register port. It clears bits by writing 1 to them. An enable register masks the status into one registered, active-high interrupt line.

A select bit in a control register picks the completion event that sets the receive-OK and receive-error bits. The choice is between the end of the host-side receive DMA and the end of the local receive DMA. The fragment bit is raised when the host DMA fragment count is smaller than the length of the packet now arriving. This comparison runs only on the cycle the length is marked valid.

Top module: `eth_irq_status`

## Requirements
- R1: After reset the status register (address 0), the enable register (address 1) and the control register (address 2) read 0x00, and `irq` is low.
- R2: Each source sets its own status bit on the clock edge where its pulse is sampled: bit 0 fragment, bit 1 receive OK, bit 2 transmit OK, bit 3 receive error, bit 4 transmit error, bit 5 FIFO error, bit 6 bus error, bit 7 receive buffer full. A set bit stays set until the host clears it.
- R3: A write to address 0 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a set event and a write-1 clear hit the same bit on the same edge, the bit ends up set.
- R5: When control bit 4 is 1, only `rx_host_ok` and `rx_host_err` set status bits 1 and 3, and the local completion pulses are ignored. When control bit 4 is 0, only `rx_local_ok` and `rx_local_err` set them, and the host pulses are ignored.
- R6: Status bit 0 is set only on a cycle with `pkt_len_vld` high and `frag_cnt` < `pkt_len`, compared as 16-bit unsigned numbers. An equal or larger count, or a cycle without the strobe, leaves the bit unchanged.
- R7: Status bit 5 is set by an overrun pulse from either the TX FIFO or the RX FIFO.
- R8: Status bit 6 is set by `bus_chk_fail` only while `bus_chk_en` is high.
- R9: `irq` equals the OR of (status AND enable) as it stood one clock earlier.
- R10: Reads change no state. The enable register reads back the last value written to it. The control register stores only bit 4, and its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register address: 0 status, 1 enable, 2 control |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| rx_host_ok | input | 1 | Host receive DMA finished, packet good |
| rx_host_err | input | 1 | Host receive DMA finished, packet in error |
| rx_local_ok | input | 1 | Local receive DMA finished, packet good |
| rx_local_err | input | 1 | Local receive DMA finished, packet in error |
| tx_ok | input | 1 | Packet transmitted without error |
| tx_err | input | 1 | Packet transmitted with error |
| txfifo_ovr | input | 1 | TX FIFO overrun |
| rxfifo_ovr | input | 1 | RX FIFO overrun |
| bus_chk_en | input | 1 | Bus integrity checking enabled |
| bus_chk_fail | input | 1 | Bus integrity check failed |
| rxbuf_wrap | input | 1 | New packets are overwriting the receive buffer area |
| frag_cnt | input | 16 | Host DMA fragment counter |
| pkt_len | input | 16 | Length of the packet being received |
| pkt_len_vld | input | 1 | Strobe that qualifies `pkt_len` |
| irq | output | 1 | Interrupt request, active high |

## Verification
A bad status bit can be seen on `host_rdata` at address 0 on the cycle right after the edge that latched it. Through `irq` it can be seen one cycle later still, so every fault can be observed within two clocks of the stimulus.

A lost or wrong receive-source selection shows up as the wrong bit, or as no bit, after a single completion pulse. A wrong clear priority shows up as a bit missing after a write that arrives together with its event. A wrong fragment comparison shows up only at the equal and off-by-one lengths, so those lengths are driven on purpose.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

   // Status bit positions; host software decodes these.
   localparam int BIT_FRAG  = 0;
   localparam int BIT_RXOK  = 1;
   localparam int BIT_TXOK  = 2;
   localparam int BIT_RXERR = 3;
   localparam int BIT_TXERR = 4;
   localparam int BIT_FIFO  = 5;
   localparam int BIT_BUS   = 6;
   localparam int BIT_RXBUF = 7;
   localparam int NUM_SRC   = 8;

   typedef logic [NUM_SRC-1:0] irq_vec_t;

   typedef struct packed {
      logic rx_host_ok;
      logic rx_host_err;
      logic rx_local_ok;
      logic rx_local_err;
      logic tx_ok;
      logic tx_err;
      logic txfifo_ovr;
      logic rxfifo_ovr;
      logic bus_chk_en;
      logic bus_chk_fail;
      logic rxbuf_wrap;
   } irq_evt_t;

endpackage

// File: rtl/irqs_frag_cmp.sv
module irqs_frag_cmp #(
   parameter int LEN_W   = 16,
   parameter bit REG_CMP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] frag_cnt,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             len_vld,
   output logic             frag_hit
);

   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("irqs_frag_cmp: LEN_W must be at least 1");
      end
   endgenerate

   logic short_w;
   assign short_w = len_vld && (frag_cnt < pkt_len);

   generate
      if (REG_CMP) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= short_w;
         end
         assign frag_hit = hit_q;
      end else begin : g_comb
         assign frag_hit = short_w;
      end
   endgenerate

endmodule

// File: rtl/irqs_src_map.sv
module irqs_src_map
   import irqs_pkg::*;
(
   input  irq_evt_t evt,
   input  logic     rx_sel_host,
   input  logic     frag_hit,
   output irq_vec_t set_vec
);

   logic rx_ok_w;
   logic rx_err_w;

   always_comb begin
      if (rx_sel_host) begin
         rx_ok_w  = evt.rx_host_ok;
         rx_err_w = evt.rx_host_err;
      end else begin
         rx_ok_w  = evt.rx_local_ok;
         rx_err_w = evt.rx_local_err;
      end
   end

   always_comb begin
      set_vec            = '0;
      set_vec[BIT_FRAG]  = frag_hit;
      set_vec[BIT_RXOK]  = rx_ok_w;
      set_vec[BIT_TXOK]  = evt.tx_ok;
      set_vec[BIT_RXERR] = rx_err_w;
      set_vec[BIT_TXERR] = evt.tx_err;
      set_vec[BIT_FIFO]  = evt.txfifo_ovr | evt.rxfifo_ovr;
      set_vec[BIT_BUS]   = evt.bus_chk_en & evt.bus_chk_fail;
      set_vec[BIT_RXBUF] = evt.rxbuf_wrap;
   end

endmodule

// File: rtl/irqs_sticky.sv
module irqs_sticky #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] stat_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("irqs_sticky: WIDTH must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;
            else if (clr_i[i]) bit_q <= 1'b0;
         end
         assign stat_o[i] = bit_q;

         AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_q && !clr_i[i]) |=> bit_q); // R2
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> bit_q); // R4
         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !bit_q); // R3
      end
   endgenerate

endmodule

// File: rtl/eth_irq_status.sv
module eth_irq_status
   import irqs_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int LEN_W      = 16,
   parameter int STAT_ADDR  = 0,
   parameter int EN_ADDR    = 1,
   parameter int CTRL_ADDR  = 2,
   parameter int RX_SEL_BIT = 4,
   parameter bit FRAG_REG   = 1'b0,
   parameter bit IRQ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              rx_host_ok,
   input  logic              rx_host_err,
   input  logic              rx_local_ok,
   input  logic              rx_local_err,
   input  logic              tx_ok,
   input  logic              tx_err,
   input  logic              txfifo_ovr,
   input  logic              rxfifo_ovr,
   input  logic              bus_chk_en,
   input  logic              bus_chk_fail,
   input  logic              rxbuf_wrap,
   input  logic [LEN_W-1:0]  frag_cnt,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic              pkt_len_vld,
   output logic              irq
);

   localparam int REG_W = NUM_SRC;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("eth_irq_status: ADDR_W must hold three addresses");
      end
      if (RX_SEL_BIT < 0 || RX_SEL_BIT >= REG_W) begin : g_bad_sel
         $error("eth_irq_status: RX_SEL_BIT out of register range");
      end
      if (STAT_ADDR == EN_ADDR || STAT_ADDR == CTRL_ADDR || EN_ADDR == CTRL_ADDR) begin : g_bad_map
         $error("eth_irq_status: register addresses must differ");
      end
      if (STAT_ADDR >= (1 << ADDR_W) || EN_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("eth_irq_status: register address exceeds ADDR_W");
      end
   endgenerate

   // Host write decode
   logic wr_stat, wr_en, wr_ctrl;
   assign wr_stat = host_wr && (host_addr == A_STAT);
   assign wr_en   = host_wr && (host_addr == A_EN);
   assign wr_ctrl = host_wr && (host_addr == A_CTRL);

   // Enable and control registers
   logic [REG_W-1:0] en_q;
   logic             rx_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         rx_sel_q <= 1'b0;
      end else begin
         if (wr_en)   en_q     <= host_wdata;
         if (wr_ctrl) rx_sel_q <= host_wdata[RX_SEL_BIT];
      end
   end

   // Event sources
   irq_evt_t evt_w;
   always_comb begin
      evt_w.rx_host_ok   = rx_host_ok;
      evt_w.rx_host_err  = rx_host_err;
      evt_w.rx_local_ok  = rx_local_ok;
      evt_w.rx_local_err = rx_local_err;
      evt_w.tx_ok        = tx_ok;
      evt_w.tx_err       = tx_err;
      evt_w.txfifo_ovr   = txfifo_ovr;
      evt_w.rxfifo_ovr   = rxfifo_ovr;
      evt_w.bus_chk_en   = bus_chk_en;
      evt_w.bus_chk_fail = bus_chk_fail;
      evt_w.rxbuf_wrap   = rxbuf_wrap;
   end

   logic frag_hit_w;

   irqs_frag_cmp #(
      .LEN_W   (LEN_W),
      .REG_CMP (FRAG_REG)
   ) frag_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .frag_cnt (frag_cnt),
      .pkt_len  (pkt_len),
      .len_vld  (pkt_len_vld),
      .frag_hit (frag_hit_w)
   );

   irq_vec_t set_w;

   irqs_src_map map_i (
      .evt         (evt_w),
      .rx_sel_host (rx_sel_q),
      .frag_hit    (frag_hit_w),
      .set_vec     (set_w)
   );

   logic [REG_W-1:0] clr_w;
   logic [REG_W-1:0] stat_w;
   assign clr_w = wr_stat ? host_wdata : '0;

   irqs_sticky #(
      .WIDTH (REG_W)
   ) sticky_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_w),
      .clr_i  (clr_w),
      .stat_o (stat_w)
   );

   // Read mux
   logic [7:0] ctrl_rd;
   always_comb begin
      ctrl_rd             = '0;
      ctrl_rd[RX_SEL_BIT] = rx_sel_q;
   end

   always_comb begin
      if (host_addr == A_STAT)      host_rdata = stat_w;
      else if (host_addr == A_EN)   host_rdata = en_q;
      else if (host_addr == A_CTRL) host_rdata = ctrl_rd;
      else                          host_rdata = '0;
   end

   // Interrupt output
   logic pend_w;
   assign pend_w = |(stat_w & en_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend_w;
         end
         assign irq = irq_q;

         AST_IRQ_LAGS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq == $past(|(stat_w & en_q)))); // R9
      end else begin : g_irq_comb
         assign irq = pend_w;
      end
   endgenerate

   generate
      if (!FRAG_REG) begin : g_frag_chk
         AST_FRAG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            (!pkt_len_vld && !stat_w[BIT_FRAG]) |=> !stat_w[BIT_FRAG]); // R6
      end
   endgenerate

   AST_BUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_chk_en && !stat_w[BIT_BUS]) |=> !stat_w[BIT_BUS]); // R8

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q)); // R10

   AST_STAT_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stat) |=> ((stat_w & $past(stat_w)) == $past(stat_w))); // R3

endmodule

// File: tb/eth_irq_status_tb_top.sv
module eth_irq_status_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        rx_host_ok = 0, rx_host_err = 0, rx_local_ok = 0, rx_local_err = 0;
   logic        tx_ok = 0, tx_err = 0, txfifo_ovr = 0, rxfifo_ovr = 0;
   logic        bus_chk_en = 0, bus_chk_fail = 0, rxbuf_wrap = 0;
   logic [15:0] frag_cnt = '0;
   logic [15:0] pkt_len = '0;
   logic        pkt_len_vld = 1'b0;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk; // 50 MHz

   eth_irq_status dut_i (
      .clk (clk), .rst_n (rst_n),
      .host_addr (host_addr), .host_wr (host_wr),
      .host_wdata (host_wdata), .host_rdata (host_rdata),
      .rx_host_ok (rx_host_ok), .rx_host_err (rx_host_err),
      .rx_local_ok (rx_local_ok), .rx_local_err (rx_local_err),
      .tx_ok (tx_ok), .tx_err (tx_err),
      .txfifo_ovr (txfifo_ovr), .rxfifo_ovr (rxfifo_ovr),
      .bus_chk_en (bus_chk_en), .bus_chk_fail (bus_chk_fail),
      .rxbuf_wrap (rxbuf_wrap),
      .frag_cnt (frag_cnt), .pkt_len (pkt_len), .pkt_len_vld (pkt_len_vld),
      .irq (irq)
   );

   // Vector: {ctrl select, events[10:0], expected status}
   // events: [10] rxbuf [9] bus_en [8] bus_fail [7] rxfifo [6] txfifo
   //         [5] tx_err [4] tx_ok [3] local_err [2] local_ok [1] host_err [0] host_ok
   localparam int NVEC = 14;
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b1, 11'b000_0000_0001, 8'h02},
      {1'b1, 11'b000_0000_0010, 8'h08},
      {1'b1, 11'b000_0000_1100, 8'h00},
      {1'b0, 11'b000_0000_0100, 8'h02},
      {1'b0, 11'b000_0000_1000, 8'h08},
      {1'b0, 11'b000_0000_0011, 8'h00},
      {1'b0, 11'b000_0001_0000, 8'h04},
      {1'b0, 11'b000_0010_0000, 8'h10},
      {1'b0, 11'b000_0100_0000, 8'h20},
      {1'b0, 11'b000_1000_0000, 8'h20},
      {1'b0, 11'b011_0000_0000, 8'h40},
      {1'b0, 11'b001_0000_0000, 8'h00},
      {1'b0, 11'b100_0000_0000, 8'h80},
      {1'b0, 11'b111_1111_1111, 8'hFE}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wr = 1'b1; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic drive_ev(input logic [10:0] e);
      rx_host_ok   = e[0];
      rx_host_err  = e[1];
      rx_local_ok  = e[2];
      rx_local_err = e[3];
      tx_ok        = e[4];
      tx_err       = e[5];
      txfifo_ovr   = e[6];
      rxfifo_ovr   = e[7];
      bus_chk_fail = e[8];
      bus_chk_en   = e[9];
      rxbuf_wrap   = e[10];
   endtask

   task automatic pulse(input logic [10:0] e);
      @(negedge clk);
      drive_ev(e);
      @(negedge clk);
      drive_ev('0);
   endtask

   task automatic frag(input logic [15:0] c, input logic [15:0] l, input logic v,
                       input logic [7:0] exp, input string req);
      logic [7:0] r;
      wr(2'd0, 8'hFF);
      frag_cnt = c; pkt_len = l; pkt_len_vld = v;
      @(negedge clk);
      pkt_len_vld = 1'b0;
      rd(2'd0, r);
      chk(req, r, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      rd(2'd0, r); chk("R1 status", r, 8'h00);
      rd(2'd1, r); chk("R1 enable", r, 8'h00);
      rd(2'd2, r); chk("R1 control", r, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);

      wr(2'd1, 8'hFF);

      // Vector table: R2, R5, R7, R8, R9
      for (int i = 0; i < NVEC; i++) begin
         wr(2'd2, {3'b000, VEC[i][19], 4'b0000});
         wr(2'd0, 8'hFF);
         pulse(VEC[i][18:8]);
         rd(2'd0, r);
         chk($sformatf("R2/R5/R7/R8 vector %0d status", i), r, VEC[i][7:0]);
         @(negedge clk);
         chk($sformatf("R9 vector %0d irq", i), {7'd0, irq}, {7'd0, (VEC[i][7:0] != 8'h00)});
      end

      // R2: stickiness over idle cycles
      wr(2'd0, 8'hFF);
      pulse(11'b000_0011_0000);
      repeat (5) @(negedge clk);
      rd(2'd0, r); chk("R2 sticky after idle", r, 8'h14);

      // R3: write-1 clears, write-0 keeps
      wr(2'd0, 8'h04);
      rd(2'd0, r); chk("R3 clear bit 2", r, 8'h10);
      wr(2'd0, 8'h00);
      rd(2'd0, r); chk("R3 write zero", r, 8'h10);

      // R4: set wins over simultaneous clear
      @(negedge clk);
      host_addr = 2'd0; host_wr = 1'b1; host_wdata = 8'h10; tx_err = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; tx_err = 1'b0;
      rd(2'd0, r); chk("R4 set beats clear", r, 8'h10);

      // R10: reads leave status alone
      repeat (4) begin
         rd(2'd0, r);
         @(negedge clk);
      end
      rd(2'd0, r); chk("R10 read has no effect", r, 8'h10);

      // R9: masking and one-cycle lag (status 0x10 here)
      wr(2'd1, 8'h0F);
      @(negedge clk);
      chk("R9 masked irq low", {7'd0, irq}, 8'h00);
      @(negedge clk);
      host_addr = 2'd1; host_wr = 1'b1; host_wdata = 8'h10;
      @(negedge clk);
      host_wr = 1'b0;
      chk("R9 irq not yet", {7'd0, irq}, 8'h00);
      @(negedge clk);
      chk("R9 irq after one cycle", {7'd0, irq}, 8'h01);

      // R10: register read-back
      wr(2'd1, 8'h5A);
      rd(2'd1, r); chk("R10 enable readback", r, 8'h5A);
      wr(2'd2, 8'hFF);
      rd(2'd2, r); chk("R10 control only bit 4", r, 8'h10);
      wr(2'd2, 8'hEF);
      rd(2'd2, r); chk("R10 control bit 4 zero", r, 8'h00);

      // R6: fragment comparator boundaries
      frag(16'd10,   16'd11,   1'b1, 8'h01, "R6 count below length");
      frag(16'd11,   16'd11,   1'b1, 8'h00, "R6 count equal");
      frag(16'd12,   16'd11,   1'b1, 8'h00, "R6 count above");
      frag(16'd0,    16'd100,  1'b0, 8'h00, "R6 no strobe");
      frag(16'hFFFE, 16'hFFFF, 1'b1, 8'h01, "R6 unsigned top");
      frag(16'h8000, 16'h7FFF, 1'b1, 8'h00, "R6 unsigned high count");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule